// File: doc/BRIEF.md
# Password-Gated Memory Access Controller

This block decides, for every read or write request aimed at a small nonvolatile-style memory, whether the request may proceed. It holds an access code of one to eight bytes with its stored length. It also holds a movable partition pointer, an access-enabled flag and a write-enabled flag. Addresses below the pointer form the protected region. Addresses at or above it form the open region. The code, the pointer and the flags together choose between three behaviours. With no code set the block is fully open. With no code but a nonzero pointer, the covered region is write-protected. With a code set, the block is either locked or unlocked.

A command decoder in front of the block presents one command per cycle while the select line is high. The command can be a memory access, one byte of code entry, the end of an entry, or a configuration change. The block answers one cycle later with a valid strobe, an error flag and, for granted reads, the data. A register-based array stands in for the real cells. It can be organised as 512 bytes or as 256 words of 16 bits, and the pointer is compared in the active unit.

Top module: `pwg_top`

## Requirements
- R1: The stored code length is always between 0 and 8. A set-length command (op 5, length in cmd_data) whose value exceeds 8 is rejected with an error and leaves the length unchanged.
- R2: After reset the code length is 0, the pointer is 0, and both access-enabled and write-enabled are clear. A write or write-enable-gated command needs write-enabled, which is set by op 8 and cleared by op 9. With no code and a zero pointer, every address can be written and read back.
- R3: With no code and a nonzero pointer, a write below the pointer is refused and leaves memory unchanged unless cmd_ovr is 1. Reads anywhere succeed, and writes at or above the pointer succeed.
- R4: With a code set and access not enabled, reads and writes below the pointer are refused with error and zero data, even when cmd_ovr is 1. The region at or above the pointer is read-only.
- R5: With a code set and access enabled, the region below the pointer can be read and written, and the region at or above it stays read-only.
- R6: Code entry sends bytes with op 3 (byte in cmd_data[7:0]) and ends with op 4. Access becomes enabled only when exactly the stored number of bytes matched in order. Otherwise op 4 answers with error and access-enabled is cleared.
- R7: While sel is low, commands are ignored with no response, and any partial code entry is discarded. Neither flag changes. Op 10 clears access-enabled.
- R8: In byte mode (word_mode 0), address bit 0 picks the low (0) or high (1) byte of word address[8:1], and reads return the byte zero-extended. In word mode, addresses 0 to 255 name 16-bit words, and addresses of 256 or more are refused. The pointer is compared in the active unit.
- R9: Set-length, set-code-byte (op 6, index cmd_addr[2:0], byte cmd_data[7:0]) and set-pointer (op 7, value cmd_addr) take effect only when write-enabled is set and either no code is set or access is enabled. Otherwise they answer with error and change nothing.
- R10: Every command accepted while sel is high gets exactly one response on the next cycle. Unknown opcodes answer with error. Op 1 is read and op 2 is write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sel | input | 1 | Select; low discards entry in progress and ignores commands |
| word_mode | input | 1 | 1 selects 256 x 16 organisation, 0 selects 512 x 8 |
| cmd_vld | input | 1 | Command present this cycle |
| cmd_op | input | 4 | Command code |
| cmd_addr | input | 9 | Address, pointer value or code byte index |
| cmd_data | input | 16 | Write data, code byte or code length |
| cmd_ovr | input | 1 | Override of write protection when no code is set |
| rsp_vld | output | 1 | Response strobe, one cycle after the command |
| rsp_err | output | 1 | Command refused or entry failed |
| rsp_data | output | 16 | Read data for granted reads, otherwise zero |
| acc_en | output | 1 | Access-enabled flag |
| wr_en | output | 1 | Write-enabled flag |

## Verification
Every response appears one clock edge after the command is sampled. The command, the permission decision and the array read all register into the same output stage. The bench therefore drives each command on a falling edge and samples rsp_vld, rsp_err and rsp_data on the following falling edge. The flag outputs change on that same edge, so they are read at that same point. For the sel-low cases, the bench holds sel low across at least one rising edge before it samples. That way, an ignored command or a discarded entry would already have shown up in the response or in a later failed entry.

// File: rtl/pwg_pkg.sv
package pwg_pkg;

  typedef enum logic [3:0] {
    OP_NOP     = 4'd0,
    OP_READ    = 4'd1,
    OP_WRITE   = 4'd2,
    OP_ENTER   = 4'd3,
    OP_DONE    = 4'd4,
    OP_SETLEN  = 4'd5,
    OP_SETBYTE = 4'd6,
    OP_SETPTR  = 4'd7,
    OP_WREN    = 4'd8,
    OP_WRDIS   = 4'd9,
    OP_LOCK    = 4'd10
  } op_e;

  localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/pwg_code_store.sv
module pwg_code_store #(
  parameter int unsigned CODE_BYTES = 8,
  parameter int unsigned LEN_W      = $clog2(CODE_BYTES + 1),
  parameter int unsigned IDX_W      = (CODE_BYTES > 1) ? $clog2(CODE_BYTES) : 1
) (
  input  logic             clk,
  input  logic             rst_l,
  input  logic             sel,
  input  logic             enter_stb,
  input  logic             done_stb,
  input  logic [7:0]       in_byte,
  input  logic             set_len_stb,
  input  logic [LEN_W-1:0] set_len_val,
  input  logic             set_byte_stb,
  input  logic [IDX_W-1:0] set_byte_idx,
  input  logic [7:0]       set_byte_val,
  output logic             code_set,
  output logic             entry_ok
);

  logic [7:0]       code_q [CODE_BYTES];
  logic [LEN_W-1:0] len_q, len_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic             mism_q, mism_d;

  // code bytes: one enabled register per byte
  for (genvar b = 0; b < CODE_BYTES; b++) begin : g_byte
    logic ld;
    assign ld = set_byte_stb && (set_byte_idx == IDX_W'(b));
    always_ff @(posedge clk or negedge rst_l) begin
      if (!rst_l)  code_q[b] <= '0;
      else if (ld) code_q[b] <= set_byte_val;
    end
  end

  always_comb begin
    len_d = len_q;
    if (set_len_stb) len_d = set_len_val;
  end

  always_comb begin
    cnt_d  = cnt_q;
    mism_d = mism_q;
    if (!sel || done_stb) begin
      cnt_d  = '0;
      mism_d = 1'b0;
    end else if (enter_stb) begin
      if (cnt_q < len_q) begin
        if (code_q[cnt_q[IDX_W-1:0]] != in_byte) mism_d = 1'b1;
      end else begin
        mism_d = 1'b1;
      end
      if (cnt_q != '1) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      len_q  <= '0;
      cnt_q  <= '0;
      mism_q <= 1'b0;
    end else begin
      len_q  <= len_d;
      cnt_q  <= cnt_d;
      mism_q <= mism_d;
    end
  end

  assign code_set = (len_q != '0);
  assign entry_ok = code_set && !mism_q && (cnt_q == len_q);

  AST_LEN_LIMIT: assert property (@(posedge clk) disable iff (!rst_l)
    len_q <= LEN_W'(CODE_BYTES)); // R1

  AST_ENTRY_ABORT: assert property (@(posedge clk) disable iff (!rst_l)
    !sel |=> (cnt_q == '0) && !mism_q); // R7

endmodule

// File: rtl/pwg_perm.sv
module pwg_perm #(
  parameter int unsigned ADDR_W = 9
) (
  input  logic              word_mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] ptr,
  input  logic              is_wr,
  input  logic              ovr,
  input  logic              code_set,
  input  logic              acc_en,
  input  logic              wr_en,
  output logic              grant
);

  logic [ADDR_W-1:0] unit_addr;
  logic              in_range;
  logic              prot;

  always_comb begin
    unit_addr = word_mode ? {1'b0, addr[ADDR_W-2:0]} : addr;
    in_range  = !word_mode || !addr[ADDR_W-1];
    prot      = unit_addr < ptr;
    grant     = 1'b0;
    if (in_range) begin
      if (!is_wr) begin
        grant = !(code_set && !acc_en && prot);
      end else if (wr_en) begin
        if (code_set) grant = prot && acc_en;
        else          grant = !prot || ovr;
      end
    end
  end

endmodule

// File: rtl/pwg_array.sv
module pwg_array #(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned LANES     = DATA_W / 8,
  localparam int unsigned MEM_WORDS = 2 ** (ADDR_W - 1),
  localparam int unsigned WIDX_W    = ADDR_W - 1
) (
  input  logic              clk,
  input  logic              rst_l,
  input  logic              word_mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic              re,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [WIDX_W-1:0] widx;
  logic [LANES-1:0]  lane_en;
  logic [7:0]        lane_rd [LANES];
  logic [DATA_W-1:0] word_rd;
  logic [DATA_W-1:0] rd_d, rd_q;

  assign widx = word_mode ? addr[WIDX_W-1:0] : addr[ADDR_W-1:1];

  always_comb begin
    lane_en = '0;
    if (word_mode) lane_en = '1;
    else           lane_en[addr[0]] = 1'b1;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0] mem_l [MEM_WORDS];
    logic [7:0] wd;
    assign wd = word_mode ? wdata[8*l +: 8] : wdata[7:0];
    always_ff @(posedge clk) begin
      if (we && lane_en[l]) mem_l[widx] <= wd;
    end
    assign lane_rd[l]       = mem_l[widx];
    assign word_rd[8*l +: 8] = lane_rd[l];
  end

  always_comb begin
    rd_d = '0;
    if (re) begin
      if (word_mode) rd_d = word_rd;
      else           rd_d[7:0] = addr[0] ? lane_rd[1] : lane_rd[0];
    end
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) rd_q <= '0;
    else        rd_q <= rd_d;
  end

  assign rdata = rd_q;

endmodule

// File: rtl/pwg_top.sv
module pwg_top
  import pwg_pkg::*;
#(
  parameter int unsigned ADDR_W     = 9,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned CODE_BYTES = 8,
  localparam int unsigned LEN_W     = $clog2(CODE_BYTES + 1),
  localparam int unsigned IDX_W     = (CODE_BYTES > 1) ? $clog2(CODE_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              word_mode,
  input  logic              cmd_vld,
  input  logic [3:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              cmd_ovr,
  output logic              rsp_vld,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_data,
  output logic              acc_en,
  output logic              wr_en
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_l;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_l = rs_q[1];

  op_e  op;
  logic take;
  assign op   = op_e'(cmd_op);
  assign take = sel && cmd_vld;

  logic              code_set, entry_ok, grant, cfg_ok, len_bad;
  logic              acc_en_q, acc_en_d, wr_en_q, wr_en_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic              vld_q, err_q, err_d;
  logic              enter_stb, done_stb, set_len_stb, set_byte_stb;
  logic              mem_we, mem_re;

  assign cfg_ok  = wr_en_q && (!code_set || acc_en_q);
  assign len_bad = cmd_data > DATA_W'(CODE_BYTES);

  pwg_perm #(.ADDR_W(ADDR_W)) u_perm (
    .word_mode (word_mode),
    .addr      (cmd_addr),
    .ptr       (ptr_q),
    .is_wr     (op == OP_WRITE),
    .ovr       (cmd_ovr),
    .code_set  (code_set),
    .acc_en    (acc_en_q),
    .wr_en     (wr_en_q),
    .grant     (grant)
  );

  always_comb begin
    acc_en_d     = acc_en_q;
    wr_en_d      = wr_en_q;
    ptr_d        = ptr_q;
    err_d        = 1'b0;
    enter_stb    = 1'b0;
    done_stb     = 1'b0;
    set_len_stb  = 1'b0;
    set_byte_stb = 1'b0;
    mem_we       = 1'b0;
    mem_re       = 1'b0;
    if (take) begin
      unique case (op)
        OP_READ: begin
          mem_re = grant;
          err_d  = !grant;
        end
        OP_WRITE: begin
          mem_we = grant;
          err_d  = !grant;
        end
        OP_ENTER: enter_stb = 1'b1;
        OP_DONE: begin
          done_stb = 1'b1;
          acc_en_d = entry_ok;
          err_d    = !entry_ok;
        end
        OP_SETLEN: begin
          set_len_stb = cfg_ok && !len_bad;
          err_d       = !cfg_ok || len_bad;
        end
        OP_SETBYTE: begin
          set_byte_stb = cfg_ok;
          err_d        = !cfg_ok;
        end
        OP_SETPTR: begin
          if (cfg_ok) ptr_d = cmd_addr;
          err_d = !cfg_ok;
        end
        OP_WREN:  wr_en_d  = 1'b1;
        OP_WRDIS: wr_en_d  = 1'b0;
        OP_LOCK:  acc_en_d = 1'b0;
        default:  err_d    = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      acc_en_q <= 1'b0;
      wr_en_q  <= 1'b0;
      ptr_q    <= '0;
      vld_q    <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      acc_en_q <= acc_en_d;
      wr_en_q  <= wr_en_d;
      ptr_q    <= ptr_d;
      vld_q    <= take;
      err_q    <= err_d;
    end
  end

  pwg_code_store #(.CODE_BYTES(CODE_BYTES)) u_code (
    .clk          (clk),
    .rst_l        (rst_l),
    .sel          (sel),
    .enter_stb    (enter_stb),
    .done_stb     (done_stb),
    .in_byte      (cmd_data[7:0]),
    .set_len_stb  (set_len_stb),
    .set_len_val  (cmd_data[LEN_W-1:0]),
    .set_byte_stb (set_byte_stb),
    .set_byte_idx (cmd_addr[IDX_W-1:0]),
    .set_byte_val (cmd_data[7:0]),
    .code_set     (code_set),
    .entry_ok     (entry_ok)
  );

  pwg_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk       (clk),
    .rst_l     (rst_l),
    .word_mode (word_mode),
    .addr      (cmd_addr),
    .we        (mem_we),
    .re        (mem_re),
    .wdata     (cmd_data),
    .rdata     (rsp_data)
  );

  assign rsp_vld = vld_q;
  assign rsp_err = err_q;
  assign acc_en  = acc_en_q;
  assign wr_en   = wr_en_q;

  AST_LOCKED_READ_DENY: assert property (@(posedge clk) disable iff (!rst_l)
    (take && cmd_op == 4'd1 && !word_mode && code_set && !acc_en_q && (cmd_addr < ptr_q))
    |=> (rsp_err && rsp_data == '0)); // R4

  AST_CODED_OPEN_RO: assert property (@(posedge clk) disable iff (!rst_l)
    (take && cmd_op == 4'd2 && !word_mode && code_set && (cmd_addr >= ptr_q))
    |=> rsp_err); // R5

  AST_SEL_LOW_HOLD: assert property (@(posedge clk) disable iff (!rst_l)
    !sel |=> ($stable(acc_en_q) && $stable(wr_en_q) && !rsp_vld)); // R7

  AST_ONE_CYCLE_RSP: assert property (@(posedge clk) disable iff (!rst_l)
    take |=> rsp_vld); // R10

  AST_WORD_RANGE: assert property (@(posedge clk) disable iff (!rst_l)
    (take && word_mode && cmd_addr[ADDR_W-1] && (cmd_op == 4'd1 || cmd_op == 4'd2))
    |=> rsp_err); // R8

endmodule

// File: tb/tb_pwg_top.sv
module tb_pwg_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sel, word_mode, cmd_vld, cmd_ovr;
  logic [3:0]  cmd_op;
  logic [8:0]  cmd_addr;
  logic [15:0] cmd_data;
  logic        rsp_vld, rsp_err, acc_en, wr_en;
  logic [15:0] rsp_data;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  pwg_top dut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .word_mode(word_mode),
    .cmd_vld(cmd_vld), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .cmd_ovr(cmd_ovr),
    .rsp_vld(rsp_vld), .rsp_err(rsp_err), .rsp_data(rsp_data),
    .acc_en(acc_en), .wr_en(wr_en)
  );

  typedef struct packed {
    logic [3:0]  op;
    logic [8:0]  addr;
    logic [15:0] data;
    logic        ovr;
    logic        err;
    logic [15:0] rdat;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 34;
  localparam vec_t VEC [NV] = '{
    '{4'd8, 9'h000, 16'h0000, 1'b0, 1'b0, 16'h0000, 4'd2},  // R2 write enable
    '{4'd2, 9'h005, 16'h0011, 1'b0, 1'b0, 16'h0000, 4'd2},  // R2
    '{4'd1, 9'h005, 16'h0000, 1'b0, 1'b0, 16'h0011, 4'd2},  // R2
    '{4'd2, 9'h1FF, 16'h0022, 1'b0, 1'b0, 16'h0000, 4'd8},  // R8 high byte
    '{4'd1, 9'h1FF, 16'h0000, 1'b0, 1'b0, 16'h0022, 4'd8},  // R8
    '{4'd7, 9'h010, 16'h0000, 1'b0, 1'b0, 16'h0000, 4'd9},  // R9 pointer
    '{4'd2, 9'h005, 16'h0033, 1'b0, 1'b1, 16'h0000, 4'd3},  // R3 protected
    '{4'd1, 9'h005, 16'h0000, 1'b0, 1'b0, 16'h0011, 4'd3},  // R3 unchanged
    '{4'd2, 9'h005, 16'h0044, 1'b1, 1'b0, 16'h0000, 4'd3},  // R3 override
    '{4'd1, 9'h005, 16'h0000, 1'b0, 1'b0, 16'h0044, 4'd3},  // R3
    '{4'd2, 9'h020, 16'h0055, 1'b0, 1'b0, 16'h0000, 4'd3},  // R3 open
    '{4'd5, 9'h000, 16'h0009, 1'b0, 1'b1, 16'h0000, 4'd1},  // R1 too long
    '{4'd6, 9'h000, 16'h00A5, 1'b0, 1'b0, 16'h0000, 4'd9},  // R9
    '{4'd6, 9'h001, 16'h003C, 1'b0, 1'b0, 16'h0000, 4'd9},  // R9
    '{4'd5, 9'h000, 16'h0002, 1'b0, 1'b0, 16'h0000, 4'd1},  // R1 length 2
    '{4'd1, 9'h005, 16'h0000, 1'b0, 1'b1, 16'h0000, 4'd4},  // R4
    '{4'd2, 9'h005, 16'h0077, 1'b1, 1'b1, 16'h0000, 4'd4},  // R4 ovr no help
    '{4'd1, 9'h020, 16'h0000, 1'b0, 1'b0, 16'h0055, 4'd4},  // R4 open read
    '{4'd2, 9'h020, 16'h0077, 1'b0, 1'b1, 16'h0000, 4'd4},  // R4 open ro
    '{4'd7, 9'h000, 16'h0000, 1'b0, 1'b1, 16'h0000, 4'd9},  // R9 locked
    '{4'd3, 9'h000, 16'h00A5, 1'b0, 1'b0, 16'h0000, 4'd6},  // R6
    '{4'd3, 9'h000, 16'h0000, 1'b0, 1'b0, 16'h0000, 4'd6},  // R6 wrong byte
    '{4'd4, 9'h000, 16'h0000, 1'b0, 1'b1, 16'h0000, 4'd6},  // R6
    '{4'd3, 9'h000, 16'h00A5, 1'b0, 1'b0, 16'h0000, 4'd6},  // R6
    '{4'd4, 9'h000, 16'h0000, 1'b0, 1'b1, 16'h0000, 4'd6},  // R6 short
    '{4'd3, 9'h000, 16'h00A5, 1'b0, 1'b0, 16'h0000, 4'd6},  // R6
    '{4'd3, 9'h000, 16'h003C, 1'b0, 1'b0, 16'h0000, 4'd6},  // R6
    '{4'd4, 9'h000, 16'h0000, 1'b0, 1'b0, 16'h0000, 4'd6},  // R6 good
    '{4'd2, 9'h005, 16'h0066, 1'b0, 1'b0, 16'h0000, 4'd5},  // R5
    '{4'd1, 9'h005, 16'h0000, 1'b0, 1'b0, 16'h0066, 4'd5},  // R5
    '{4'd2, 9'h020, 16'h0088, 1'b0, 1'b1, 16'h0000, 4'd5},  // R5 open ro
    '{4'd1, 9'h020, 16'h0000, 1'b0, 1'b0, 16'h0055, 4'd5},  // R5
    '{4'd10, 9'h000, 16'h0000, 1'b0, 1'b0, 16'h0000, 4'd7}, // R7 lock
    '{4'd1, 9'h005, 16'h0000, 1'b0, 1'b1, 16'h0000, 4'd7}   // R7 relocked
  };

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] op, input logic [8:0] a,
                       input logic [15:0] d, input logic ovr);
    @(negedge clk);
    cmd_op = op; cmd_addr = a; cmd_data = d; cmd_ovr = ovr; cmd_vld = 1'b1;
    @(negedge clk);
    cmd_vld = 1'b0;
  endtask

  task automatic cmd_chk(input logic [3:0] op, input logic [8:0] a,
                         input logic [15:0] d, input logic ovr,
                         input logic e_err, input logic [15:0] e_dat, input string tag);
    issue(op, a, d, ovr);
    chk({15'd0, rsp_vld}, 16'd1, {tag, " vld"});
    chk({15'd0, rsp_err}, {15'd0, e_err}, {tag, " err"});
    chk(rsp_data, e_dat, {tag, " data"});
  endtask

  task automatic wrap_up;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    wrap_up();
  end

  initial begin
    rst_n = 1'b0; sel = 1'b1; word_mode = 1'b0; cmd_vld = 1'b0;
    cmd_op = '0; cmd_addr = '0; cmd_data = '0; cmd_ovr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({15'd0, rsp_vld}, 16'd0, "R2 reset rsp_vld");
    chk({15'd0, acc_en},  16'd0, "R2 reset acc_en");
    chk({15'd0, wr_en},   16'd0, "R2 reset wr_en");
    // R2 write refused before write enable
    cmd_chk(4'd2, 9'h005, 16'h00FF, 1'b0, 1'b1, 16'h0000, "R2 no wren");

    for (int i = 0; i < NV; i++) begin
      cmd_chk(VEC[i].op, VEC[i].addr, VEC[i].data, VEC[i].ovr,
              VEC[i].err, VEC[i].rdat, $sformatf("R%0d vec%0d", VEC[i].req, i));
    end
    chk({15'd0, acc_en}, 16'd0, "R7 lock cleared acc_en");

    // R7: select drop between entry bytes discards the entry
    cmd_chk(4'd3, 9'h000, 16'h00A5, 1'b0, 1'b0, 16'h0000, "R7 entry b0");
    @(negedge clk); sel = 1'b0;
    @(negedge clk); sel = 1'b1;
    cmd_chk(4'd3, 9'h000, 16'h003C, 1'b0, 1'b0, 16'h0000, "R7 entry b1");
    cmd_chk(4'd4, 9'h000, 16'h0000, 1'b0, 1'b1, 16'h0000, "R7 aborted entry");

    // R6 correct entry again
    cmd_chk(4'd3, 9'h000, 16'h00A5, 1'b0, 1'b0, 16'h0000, "R6 b0");
    cmd_chk(4'd3, 9'h000, 16'h003C, 1'b0, 1'b0, 16'h0000, "R6 b1");
    cmd_chk(4'd4, 9'h000, 16'h0000, 1'b0, 1'b0, 16'h0000, "R6 unlock");
    chk({15'd0, acc_en}, 16'd1, "R6 acc_en set");

    // R7: commands ignored while sel low, flags persist
    @(negedge clk);
    sel = 1'b0; cmd_op = 4'd10; cmd_vld = 1'b1;
    @(negedge clk);
    chk({15'd0, rsp_vld}, 16'd0, "R7 no rsp while sel low");
    cmd_vld = 1'b0;
    repeat (2) @(negedge clk);
    sel = 1'b1;
    @(negedge clk);
    chk({15'd0, acc_en}, 16'd1, "R7 acc_en kept");
    chk({15'd0, wr_en},  16'd1, "R7 wr_en kept");

    // R8 word organisation
    word_mode = 1'b1;
    cmd_chk(4'd1, 9'h100, 16'h0000, 1'b0, 1'b1, 16'h0000, "R8 word out of range");
    cmd_chk(4'd2, 9'h008, 16'hBEEF, 1'b0, 1'b0, 16'h0000, "R8 word write");
    cmd_chk(4'd1, 9'h008, 16'h0000, 1'b0, 1'b0, 16'hBEEF, "R8 word read");
    cmd_chk(4'd2, 9'h00F, 16'h1234, 1'b0, 1'b0, 16'h0000, "R8 ptr in words");
    cmd_chk(4'd2, 9'h010, 16'h1234, 1'b0, 1'b1, 16'h0000, "R8 word at ptr ro");
    word_mode = 1'b0;
    cmd_chk(4'd1, 9'h011, 16'h0000, 1'b0, 1'b0, 16'h00BE, "R8 byte hi");
    cmd_chk(4'd1, 9'h010, 16'h0000, 1'b0, 1'b0, 16'h00EF, "R8 byte lo");
    cmd_chk(4'd1, 9'h01F, 16'h0000, 1'b0, 1'b0, 16'h0012, "R8 byte of word");

    // R10 unknown opcode
    cmd_chk(4'd15, 9'h000, 16'h0000, 1'b0, 1'b1, 16'h0000, "R10 bad op");

    // R2 / R9 write disable
    cmd_chk(4'd9, 9'h000, 16'h0000, 1'b0, 1'b0, 16'h0000, "R2 wrdis");
    chk({15'd0, wr_en}, 16'd0, "R2 wr_en cleared");
    cmd_chk(4'd2, 9'h005, 16'h0099, 1'b0, 1'b1, 16'h0000, "R2 write disabled");
    cmd_chk(4'd7, 9'h000, 16'h0000, 1'b0, 1'b1, 16'h0000, "R9 ptr needs wren");
    cmd_chk(4'd1, 9'h005, 16'h0000, 1'b0, 1'b0, 16'h0066, "R2 data intact");

    wrap_up();
  end

endmodule